// File: doc/BRIEF.md
# Secure boot address selector

This block decides where the processor fetches its first instruction. It runs while the processor is held in reset. Its inputs are a boot pin and a set of static option bits: an inverted boot option, a pin/option source select, a security enable, a boot lock, a two-bit read-protection level, a security-service command field, and three configured boot addresses (one secure, two nonsecure).

When system reset is released, or when the part comes back from standby, the block captures the boot-mode bit. It then resolves a candidate address from the selection rules. If the protection level forbids the candidate, it replaces it with a fixed fallback. It registers the result, raises a one-cycle ready pulse, and releases the processor reset on the following cycle.

The option bits are assumed to be stable from capture until the processor reset is released. Option storage, flash access and vector-table contents belong to other blocks.

Top module: `boot_vector_sel`

## Requirements
- R1: The effective boot-mode bit is `boot_pin` when `opt_pin_sel` is 1, and the inverse of `opt_boot_n` when `opt_pin_sel` is 0.
- R2: With `opt_sec_en` = 0 and `opt_lock` = 0, boot-mode 0 selects `opt_ns_addr0` and boot-mode 1 selects `opt_ns_addr1`.
- R3: With `opt_sec_en` = 1, `opt_lock` = 0 and `opt_svc_cmd` = 0, boot-mode 0 selects `opt_sec_addr` and boot-mode 1 selects the service address 0x0FF8_0000.
- R4: With `opt_sec_en` = 1, `opt_lock` = 0 and any nonzero `opt_svc_cmd`, the selected address is 0x0FF8_0000 whatever the boot mode.
- R5: With `opt_lock` = 1, the selected address is `opt_sec_addr`. Boot mode, service command and both nonsecure addresses have no effect on it.
- R6: Protection codes are 2'b00 = level 0, 2'b01 = level 0.5, 2'b10 = level 1 and 2'b11 = level 2. With `opt_sec_en` = 0 and code 2'b11, a selected address outside 0x0800_0000..0x0807_FFFF is replaced by 0x0800_0000. Any other code passes the address unchanged.
- R7: With `opt_sec_en` = 1 and a code other than 2'b00, a selected address that is neither 0x0FF8_0000 nor inside 0x0C00_0000..0x0C07_FFFF is replaced by 0x0FF8_0000. Code 2'b00 passes the address unchanged.
- R8: The boot mode is captured on the first clock after `rst_n` goes high, and again on the first clock after a `standby_exit` pulse. A `standby_exit` pulse pulls `cpu_rst_n` low on the next clock. While the processor runs, changes on the boot inputs leave `boot_addr` unchanged.
- R9: Two clocks after capture starts (the second clock edge with `rst_n` high), `boot_addr` holds the final address and `addr_ready` is high for exactly one cycle while `cpu_rst_n` is still low. `cpu_rst_n` goes high on the next clock.
- R10: While `rst_n` is low, `boot_addr` is 0, `addr_ready` is 0 and `cpu_rst_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| standby_exit | input | 1 | One-cycle pulse on return from standby |
| boot_pin | input | 1 | External boot-mode pin |
| opt_boot_n | input | 1 | Inverted boot-mode option bit |
| opt_pin_sel | input | 1 | 1: boot mode from pin, 0: from option |
| opt_sec_en | input | 1 | Security enable |
| opt_lock | input | 1 | Boot lock: force secure address |
| opt_prot | input | 2 | Read-protection level code |
| opt_svc_cmd | input | CMD_W | Security-service command |
| opt_sec_addr | input | ADDR_W | Configured secure boot address |
| opt_ns_addr0 | input | ADDR_W | Configured nonsecure boot address 0 |
| opt_ns_addr1 | input | ADDR_W | Configured nonsecure boot address 1 |
| boot_addr | output | ADDR_W | Registered final boot address |
| addr_ready | output | 1 | One-cycle pulse: address valid |
| cpu_rst_n | output | 1 | Processor reset, active low |

## Verification
The hardest case to reach from the ports is a clamp that interacts with a selection override. Examples are a locked boot whose configured secure address is out of range at an elevated protection level, or a standby re-boot whose inputs differ from the cold boot. The bench sweeps every combination of security enable, lock, zero/nonzero command, protection code and boot mode. Each combination gets addresses drawn from inside each flash window, exactly one past its end, the service address and arbitrary values. A random phase then alternates cold resets and standby exits, and changes the boot inputs while the processor is running.

// File: rtl/boot_sel_pkg.sv
// Shared types for the boot address selector.
package boot_sel_pkg;
    // Read-protection level codes
    typedef enum logic [1:0] {
        PROT_L0  = 2'b00,
        PROT_L05 = 2'b01,
        PROT_L1  = 2'b10,
        PROT_L2  = 2'b11
    } prot_lvl_e;

    // Sequencer states while the processor is held or running
    typedef enum logic [1:0] {
        ST_LATCH = 2'd0,
        ST_CALC  = 2'd1,
        ST_READY = 2'd2,
        ST_RUN   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/boot_mode_latch.sv
// Captures the effective boot-mode bit on request.
// Assumes: capture is high for one cycle per boot sequence.
module boot_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic boot_pin,
    input  logic opt_boot_n,
    input  logic opt_pin_sel,
    output logic mode_q
);
    logic eff_mode;

    // Source select: pin or inverted option bit
    always_comb eff_mode = opt_pin_sel ? boot_pin : ~opt_boot_n;

    // Hold the captured mode between capture requests
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= 1'b0;
        else if (capture) mode_q <= eff_mode;
    end
endmodule

// File: rtl/boot_addr_select.sv
// Picks the candidate boot address from the security state, lock,
// service command and captured boot mode. Purely combinational.
// Assumes: option inputs are static during resolution.
module boot_addr_select #(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = 32'h0FF8_0000
) (
    input  logic              mode,
    input  logic              sec_en,
    input  logic              lock,
    input  logic [CMD_W-1:0]  svc_cmd,
    input  logic [ADDR_W-1:0] sec_addr,
    input  logic [ADDR_W-1:0] ns_addr0,
    input  logic [ADDR_W-1:0] ns_addr1,
    output logic [ADDR_W-1:0] cand_addr
);
    // Priority: lock, then security state, then command, then mode
    always_comb begin
        if (lock)               cand_addr = sec_addr;
        else if (!sec_en)       cand_addr = mode ? ns_addr1 : ns_addr0;
        else if (|svc_cmd)      cand_addr = SVC_ADDR;
        else                    cand_addr = mode ? SVC_ADDR : sec_addr;
    end
endmodule

// File: rtl/boot_addr_clamp.sv
// Replaces a candidate address that the protection level forbids with
// the fallback for the current security state. Purely combinational.
// Assumes: windows do not wrap the address space.
module boot_addr_clamp
    import boot_sel_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] SVC_ADDR    = 32'h0FF8_0000,
    parameter logic [ADDR_W-1:0] SEC_BASE    = 32'h0C00_0000,
    parameter logic [ADDR_W-1:0] NS_BASE     = 32'h0800_0000,
    parameter logic [ADDR_W-1:0] FLASH_BYTES = 32'h0008_0000
) (
    input  logic              sec_en,
    input  logic [1:0]        prot,
    input  logic [ADDR_W-1:0] cand_addr,
    output logic [ADDR_W-1:0] final_addr
);
    localparam logic [ADDR_W-1:0] SEC_LAST = SEC_BASE + FLASH_BYTES - 1'b1;
    localparam logic [ADDR_W-1:0] NS_LAST  = NS_BASE + FLASH_BYTES - 1'b1;

    prot_lvl_e lvl;
    logic in_sec, in_ns;

    // Window decode of the candidate
    always_comb begin
        lvl    = prot_lvl_e'(prot);
        in_sec = (cand_addr >= SEC_BASE) && (cand_addr <= SEC_LAST);
        in_ns  = (cand_addr >= NS_BASE) && (cand_addr <= NS_LAST);
    end

    // Apply the protection rule for the security state
    always_comb begin
        final_addr = cand_addr;
        if (sec_en) begin
            if (lvl != PROT_L0 && !(in_sec || cand_addr == SVC_ADDR))
                final_addr = SVC_ADDR;
        end else begin
            if (lvl == PROT_L2 && !in_ns)
                final_addr = NS_BASE;
        end
    end
endmodule

// File: rtl/boot_vector_sel.sv
// Boot address selector top: sequences capture, resolution, ready pulse
// and processor reset release after system reset or standby exit.
// Assumes: options are stable from capture until cpu_rst_n rises.
module boot_vector_sel
    import boot_sel_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR    = 32'h0FF8_0000,
    parameter logic [ADDR_W-1:0] SEC_BASE    = 32'h0C00_0000,
    parameter logic [ADDR_W-1:0] NS_BASE     = 32'h0800_0000,
    parameter logic [ADDR_W-1:0] FLASH_BYTES = 32'h0008_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_exit,
    input  logic              boot_pin,
    input  logic              opt_boot_n,
    input  logic              opt_pin_sel,
    input  logic              opt_sec_en,
    input  logic              opt_lock,
    input  logic [1:0]        opt_prot,
    input  logic [CMD_W-1:0]  opt_svc_cmd,
    input  logic [ADDR_W-1:0] opt_sec_addr,
    input  logic [ADDR_W-1:0] opt_ns_addr0,
    input  logic [ADDR_W-1:0] opt_ns_addr1,
    output logic [ADDR_W-1:0] boot_addr,
    output logic              addr_ready,
    output logic              cpu_rst_n
);
    localparam logic [ADDR_W-1:0] SEC_LAST = SEC_BASE + FLASH_BYTES - 1'b1;
    localparam logic [ADDR_W-1:0] NS_LAST  = NS_BASE + FLASH_BYTES - 1'b1;

    seq_state_e        state;
    logic              mode_q;
    logic [ADDR_W-1:0] cand_addr, final_addr;

    boot_mode_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (state == ST_LATCH),
        .boot_pin    (boot_pin),
        .opt_boot_n  (opt_boot_n),
        .opt_pin_sel (opt_pin_sel),
        .mode_q      (mode_q)
    );

    boot_addr_select #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .SVC_ADDR(SVC_ADDR)) u_select (
        .mode      (mode_q),
        .sec_en    (opt_sec_en),
        .lock      (opt_lock),
        .svc_cmd   (opt_svc_cmd),
        .sec_addr  (opt_sec_addr),
        .ns_addr0  (opt_ns_addr0),
        .ns_addr1  (opt_ns_addr1),
        .cand_addr (cand_addr)
    );

    boot_addr_clamp #(
        .ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR), .SEC_BASE(SEC_BASE),
        .NS_BASE(NS_BASE), .FLASH_BYTES(FLASH_BYTES)
    ) u_clamp (
        .sec_en     (opt_sec_en),
        .prot       (opt_prot),
        .cand_addr  (cand_addr),
        .final_addr (final_addr)
    );

    // Boot sequencer: latch -> resolve -> ready pulse -> release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_LATCH;
            boot_addr  <= '0;
            addr_ready <= 1'b0;
            cpu_rst_n  <= 1'b0;
        end else begin
            case (state)
                ST_LATCH: state <= ST_CALC;
                ST_CALC: begin
                    boot_addr  <= final_addr;
                    addr_ready <= 1'b1;
                    state      <= ST_READY;
                end
                ST_READY: begin
                    addr_ready <= 1'b0;
                    cpu_rst_n  <= 1'b1;
                    state      <= ST_RUN;
                end
                default: begin
                    if (standby_exit) begin
                        cpu_rst_n <= 1'b0;
                        state     <= ST_LATCH;
                    end
                end
            endcase
        end
    end

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ready |=> !addr_ready);
    // R9
    ready_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ready |-> !cpu_rst_n);
    // R9
    release_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n) |-> $past(addr_ready));
    // R8
    run_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rst_n && $past(cpu_rst_n)) |-> $stable(boot_addr));
    // R6
    ns_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ready && !opt_sec_en && opt_prot == 2'b11)
        |-> (boot_addr >= NS_BASE && boot_addr <= NS_LAST));
    // R7
    sec_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ready && opt_sec_en && opt_prot != 2'b00)
        |-> (boot_addr == SVC_ADDR || (boot_addr >= SEC_BASE && boot_addr <= SEC_LAST)));
endmodule

// File: tb/boot_vector_sel_tb.sv
module boot_vector_sel_tb;
    localparam logic [31:0] SVC   = 32'h0FF8_0000;
    localparam logic [31:0] SBASE = 32'h0C00_0000;
    localparam logic [31:0] NBASE = 32'h0800_0000;
    localparam logic [31:0] FSIZE = 32'h0008_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0, standby_exit = 1'b0;
    logic boot_pin = 1'b0, opt_boot_n = 1'b1, opt_pin_sel = 1'b0;
    logic opt_sec_en = 1'b0, opt_lock = 1'b0;
    logic [1:0] opt_prot = 2'b00;
    logic [7:0] opt_svc_cmd = 8'h00;
    logic [31:0] opt_sec_addr = '0, opt_ns_addr0 = '0, opt_ns_addr1 = '0;
    logic [31:0] boot_addr;
    logic addr_ready, cpu_rst_n;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    boot_vector_sel u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr();
        logic m;
        logic [31:0] a;
        m = opt_pin_sel ? boot_pin : ~opt_boot_n;            // R1
        if (opt_lock) a = opt_sec_addr;                       // R5
        else if (!opt_sec_en) a = m ? opt_ns_addr1 : opt_ns_addr0; // R2
        else if (opt_svc_cmd != 0) a = SVC;                   // R4
        else a = m ? SVC : opt_sec_addr;                      // R3
        if (opt_sec_en) begin                                 // R7
            if (opt_prot != 2'b00 && a != SVC && !(a >= SBASE && a < SBASE + FSIZE)) a = SVC;
        end else if (opt_prot == 2'b11 && !(a >= NBASE && a < NBASE + FSIZE)) a = NBASE; // R6
        return a;
    endfunction

    function automatic logic [31:0] pick_addr();
        case ($urandom % 6)
            0: return SBASE + (($urandom % FSIZE) & ~32'h3);
            1: return NBASE + (($urandom % FSIZE) & ~32'h3);
            2: return SVC;
            3: return SBASE + FSIZE;
            4: return NBASE + FSIZE;
            default: return $urandom;
        endcase
    endfunction

    task automatic set_opts(input bit sec, input bit lock, input bit cmdnz,
                            input logic [1:0] prot, input bit mode);
        opt_sec_en = sec; opt_lock = lock; opt_prot = prot;
        opt_svc_cmd = cmdnz ? 8'(($urandom % 255) + 1) : 8'h00;
        opt_pin_sel = 1'($urandom);
        boot_pin = opt_pin_sel ? mode : 1'($urandom);
        opt_boot_n = opt_pin_sel ? 1'($urandom) : ~mode;
        opt_sec_addr = pick_addr(); opt_ns_addr0 = pick_addr(); opt_ns_addr1 = pick_addr();
    endtask

    // Sampling starts at the first negedge after capture has begun
    task automatic follow_boot(input string tag);
        logic [31:0] e;
        e = exp_addr();
        @(negedge clk);                    // after capture edge
        chk("R9 ready early", 32'(addr_ready), 32'd0);
        @(negedge clk);                    // after resolve edge
        chk({"R9 ready ", tag}, 32'(addr_ready), 32'd1);
        chk({"R9 held ", tag}, 32'(cpu_rst_n), 32'd0);
        chk({"R1-R7 addr ", tag}, boot_addr, e);
        @(negedge clk);                    // after release edge
        chk("R9 ready drop", 32'(addr_ready), 32'd0);
        chk("R9 release", 32'(cpu_rst_n), 32'd1);
        // R8: boot inputs moving while running have no effect
        boot_pin = ~boot_pin; opt_boot_n = ~opt_boot_n; opt_svc_cmd = ~opt_svc_cmd;
        @(negedge clk);
        chk("R8 ignored", boot_addr, e);
    endtask

    task automatic cold_boot(input bit sec, input bit lock, input bit cmdnz,
                             input logic [1:0] prot, input bit mode);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 addr", boot_addr, 32'd0);
        chk("R10 ready", 32'(addr_ready), 32'd0);
        chk("R10 cpu", 32'(cpu_rst_n), 32'd0);
        set_opts(sec, lock, cmdnz, prot, mode);
        rst_n = 1'b1;
        follow_boot("cold");
    endtask

    task automatic standby_boot(input bit sec, input bit lock, input bit cmdnz,
                                input logic [1:0] prot, input bit mode);
        set_opts(sec, lock, cmdnz, prot, mode);
        standby_exit = 1'b1;
        @(negedge clk);
        standby_exit = 1'b0;
        chk("R8 standby hold", 32'(cpu_rst_n), 32'd0);
        follow_boot("standby");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Directed sweep over all control combinations
        for (int s = 0; s < 2; s++)
            for (int l = 0; l < 2; l++)
                for (int c = 0; c < 2; c++)
                    for (int p = 0; p < 4; p++)
                        for (int m = 0; m < 2; m++)
                            cold_boot(1'(s), 1'(l), 1'(c), 2'(p), 1'(m));
        // R5: locked, out-of-range secure address at level 0.5 with security on
        @(negedge clk); rst_n = 1'b0; @(negedge clk);
        set_opts(1, 1, 1, 2'b01, 1); opt_sec_addr = SBASE + FSIZE; rst_n = 1'b1;
        follow_boot("R5 lock clamp");
        // R7: level 0 passes an out-of-range secure address unchanged
        @(negedge clk); rst_n = 1'b0; @(negedge clk);
        set_opts(1, 0, 0, 2'b00, 0); opt_sec_addr = 32'h2000_0000; rst_n = 1'b1;
        follow_boot("R7 level0");
        // Random mix of standby exits and cold boots
        for (int i = 0; i < 200; i++) begin
            if ($urandom % 3 == 0)
                cold_boot(1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
            else
                standby_boot(1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule